// File: doc/BRIEF.md
# Cursor Register Arming Controller

This block holds the four registers that describe a hardware cursor: control, screen position, surface base address, and a height-override control. Software writes them one at a time through a plain address/data/write-enable port. Each write lands in a pending copy. The live copy drives the cursor overlay, and it changes only at the start of vertical blank, and only when an update is armed at that moment.

Certain writes arm the update. Writing the base register always arms it. A control write arms it on its own only when it turns on a cursor that is currently off. Any other cursor write cancels an update that is already armed. A correct full update therefore writes the height-override, control and position registers first, and base last. Moving the cursor only takes a position write followed by a base write. The live values and the armed flag are visible as outputs.

Top module: `cursor_arm_regs`

## Requirements
- R1: After reset, all four live outputs are zero, which means the cursor is disabled, and `arm_pending` is 0.
- R2: The address map is 0 = control, 1 = position, 2 = base, 3 = height-override. A write to address 2 sets `arm_pending` on the clock edge that accepts the write.
- R3: A non-zero write to control while `live_ctrl` is zero sets `arm_pending`.
- R4: `arm_pending` is cleared, cancelling an armed update, by any of these writes: a position write, a height-override write, or a control write made while `live_ctrl` is non-zero.
- R5: A write never changes a live output directly. A `vblank_start` pulse while `arm_pending` is 0 leaves every live output unchanged, even when the pending values differ.
- R6: At the edge where `vblank_start` is high and `arm_pending` is 1, all four pending values are copied to the live outputs, and `arm_pending` clears unless a write in the same cycle arms it.
- R7: The sequence height-override, control, position, base, followed by vertical blank, makes all four new values live together. A position write followed by a base write moves the cursor at the next vertical blank.
- R8: A zero write to control while `live_ctrl` is zero does not arm an update.
- R9: When a write and an armed `vblank_start` fall in the same cycle, the transfer uses the pending values from before that write. The write updates its pending register, and its own arming rule sets the new `arm_pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 position, 2 base, 3 height-override |
| wr_data | input | DATA_W | Write data |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blank |
| live_ctrl | output | DATA_W | Live control value |
| live_pos | output | DATA_W | Live position value |
| live_base | output | DATA_W | Live base address |
| live_hovr | output | DATA_W | Live height-override value |
| arm_pending | output | 1 | An update is armed for the next vertical blank |

## Verification
A wrong armed flag shows up one cycle after the offending write on `arm_pending`. Its effect on the overlay shows later, at the next vertical blank, as a live set that moved when it should have stayed put, or the reverse. A missing copy for a single register shows only as a stale live output after a transfer, so each scenario checks all four live values after the blank. The same-cycle case separates transfer-then-write ordering from write-then-transfer ordering through the value of `live_base`.

// File: rtl/cursor_arm_regs.sv
module cursor_arm_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vblank_start,
  output logic [DATA_W-1:0] live_ctrl,
  output logic [DATA_W-1:0] live_pos,
  output logic [DATA_W-1:0] live_base,
  output logic [DATA_W-1:0] live_hovr,
  output logic              arm_pending
);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_POS  = 2'd1;
  localparam logic [1:0] A_BASE = 2'd2;
  localparam logic [1:0] A_HOVR = 2'd3;

  logic [DATA_W-1:0] pend_ctrl, pend_pos, pend_base, pend_hovr;
  logic armed;
  logic transfer;
  logic write_arms;

  assign transfer    = vblank_start && armed;
  assign write_arms  = (wr_addr == A_BASE) ||
                       ((wr_addr == A_CTRL) && (live_ctrl == '0) && (wr_data != '0));
  assign arm_pending = armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_ctrl <= '0;
      pend_pos  <= '0;
      pend_base <= '0;
      pend_hovr <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  pend_ctrl <= wr_data;
        A_POS:   pend_pos  <= wr_data;
        A_BASE:  pend_base <= wr_data;
        default: pend_hovr <= wr_data;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_ctrl <= '0;
      live_pos  <= '0;
      live_base <= '0;
      live_hovr <= '0;
    end else if (transfer) begin
      live_ctrl <= pend_ctrl;
      live_pos  <= pend_pos;
      live_base <= pend_base;
      live_hovr <= pend_hovr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b0;
    else if (wr_en)    armed <= write_arms;
    else if (transfer) armed <= 1'b0;
  end

  AST_BASE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_BASE) |=> arm_pending); // R2

  AST_POS_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_POS || wr_addr == A_HOVR)) |=> !arm_pending); // R4

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank_start && arm_pending) |=> ($stable(live_ctrl) && $stable(live_pos) &&
                                        $stable(live_base) && $stable(live_hovr))); // R5

  AST_XFER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && arm_pending) |=> (live_base == $past(pend_base))); // R6

  AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_start && arm_pending && !wr_en) |=> !arm_pending); // R6

  AST_ZERO_CTRL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data == '0) |=> !arm_pending); // R8

endmodule

// File: tb/cursor_arm_regs_tb.sv
module cursor_arm_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic vblank_start = 1'b0;
  logic [31:0] live_ctrl, live_pos, live_base, live_hovr;
  logic arm_pending;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cursor_arm_regs #(.DATA_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vblank_start(vblank_start),
    .live_ctrl(live_ctrl), .live_pos(live_pos), .live_base(live_base),
    .live_hovr(live_hovr), .arm_pending(arm_pending));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic vbl();
    vblank_start = 1'b1;
    @(posedge clk); @(negedge clk);
    vblank_start = 1'b0;
  endtask

  task automatic chk_live(string req, logic [31:0] c, logic [31:0] p,
                          logic [31:0] b, logic [31:0] h);
    chk({req, " ctrl"}, live_ctrl, c);
    chk({req, " pos"},  live_pos,  p);
    chk({req, " base"}, live_base, b);
    chk({req, " hovr"}, live_hovr, h);
  endtask

  task automatic t_reset();
    chk_live("R1 reset", 0, 0, 0, 0);
    chk("R1 armed", {31'b0, arm_pending}, 0);
  endtask

  task automatic t_enable();
    wr(2'd0, 32'h27);
    chk("R3 enable arms", {31'b0, arm_pending}, 1);
    chk("R5 write not live", live_ctrl, 0);
    vbl();
    chk_live("R6 enable xfer", 32'h27, 0, 0, 0);
    chk("R6 armed clears", {31'b0, arm_pending}, 0);
  endtask

  task automatic t_full_seq();
    wr(2'd3, 32'h15);
    wr(2'd0, 32'h22);
    chk("R4 ctrl while on no arm", {31'b0, arm_pending}, 0);
    wr(2'd1, 32'h0010_0020);
    chk("R4 pos no arm", {31'b0, arm_pending}, 0);
    wr(2'd2, 32'h1000);
    chk("R2 base arms", {31'b0, arm_pending}, 1);
    chk_live("R5 before blank", 32'h27, 0, 0, 0);
    vbl();
    chk_live("R7 full seq", 32'h22, 32'h0010_0020, 32'h1000, 32'h15);
  endtask

  task automatic t_cancel();
    wr(2'd1, 32'h55);
    wr(2'd2, 32'h2000);
    chk("R2 rearm", {31'b0, arm_pending}, 1);
    wr(2'd1, 32'h66);
    chk("R4 pos cancels", {31'b0, arm_pending}, 0);
    vbl();
    chk_live("R5 cancelled blank", 32'h22, 32'h0010_0020, 32'h1000, 32'h15);
    wr(2'd2, 32'h2000);
    wr(2'd3, 32'h9);
    chk("R4 hovr cancels", {31'b0, arm_pending}, 0);
    wr(2'd0, 32'h23);
    chk("R4 ctrl cancels", {31'b0, arm_pending}, 0);
    wr(2'd1, 32'h66);
    wr(2'd2, 32'h2000);
    vbl();
    chk_live("R7 move", 32'h23, 32'h66, 32'h2000, 32'h9);
  endtask

  task automatic t_zero_ctrl();
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h2000);
    vbl();
    chk("R6 disable xfer", live_ctrl, 0);
    wr(2'd0, 32'h0);
    chk("R8 zero ctrl no arm", {31'b0, arm_pending}, 0);
    vbl();
    chk("R5 no arm blank", live_ctrl, 0);
    wr(2'd0, 32'h27);
    chk("R3 reenable arms", {31'b0, arm_pending}, 1);
    vbl();
    chk("R3 reenable live", live_ctrl, 32'h27);
  endtask

  task automatic t_same_cycle();
    wr(2'd2, 32'h3000);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'h4000; vblank_start = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; vblank_start = 1'b0;
    chk("R9 old pending xfer", live_base, 32'h3000);
    chk("R9 write rearms", {31'b0, arm_pending}, 1);
    vbl();
    chk("R9 new base", live_base, 32'h4000);
    chk("R6 clears after", {31'b0, arm_pending}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_full_seq();
    t_cancel();
    t_zero_ctrl();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule